// File: doc/BRIEF.md
# Cache Insertion Policy Selector

This block chooses which of five insertion policies a shared cache applies to its ordinary sets. It works by set sampling. A few sample sets are tied to each policy. Every demand-miss fill into one of those sets counts as a miss against its policy. All other sets are followers, and they use the policy with the fewest counted misses. The counters saturate, and they share one aging rule: when any counter reaches its ceiling, the whole group is halved in the same cycle. Recent behaviour therefore carries more weight than old behaviour.

The same counting scheme is applied per core. Each core has a counter that advances on every fill coming from that core. A core is flagged as having a low miss rate when its counter is below one quarter of the largest core counter. The cache arrays and the fill machinery use the selected policy and the per-core flags; they are not part of this block.

Each fill is reported through a single-cycle event. The event carries the set index, a demand/prefetch bit and the originating core. Both outputs depend only on registered counters, so they reflect an event from the clock edge after it is presented.

Top module: `ips_selector`

## Requirements
- R1: While reset is held and right after it is released, `pol_sel` is 0 (policy 1) and every bit of `core_low` is 0.
- R2: The sample group is the set index modulo 128. A value k in 0..4 marks a sample set of policy k+1, which is reported as the value k on `pol_sel`. A valid demand fill into such a set adds exactly one to that policy's counter.
- R3: The policy counters do not change in any of these cases: a prefetch fill (`ins_demand` = 0), a fill into a follower set (group value 5..127), or a cycle with `ins_valid` low.
- R4: `pol_sel` gives the policy whose counter is lowest, and a tie goes to the lowest policy number. It reflects an event from the first clock edge after that event.
- R5: The policy counters are 12 bits wide. When an increment brings any of them to 4095, all five counters are halved (rounding down) on that same edge, so no counter ever holds 4095.
- R6: Each valid fill adds one to the counter of the core given on `ins_core`, whatever its type and whatever its set.
- R7: Bit i of `core_low` is 1 exactly when four times core i's counter is strictly less than the largest of the four core counters. A core at exactly one quarter is not low.
- R8: The 12-bit core counters follow the same halve-all rule as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | A fill event is present this cycle |
| ins_set | input | 11 | Set index of the fill |
| ins_demand | input | 1 | 1 = demand miss fill, 0 = prefetch fill |
| ins_core | input | 2 | Core that caused the fill |
| pol_sel | output | 3 | Policy for follower sets, 0..4 standing for policies 1..5 |
| core_low | output | 4 | Low-miss-rate flag, bit i for core i |

## Verification
The bench covers several corner cases, and each one shows a specific class of bug:
- A four-way tie among the lowest counters. A design that prefers the highest index, or the last compared entry, would report the wrong policy.
- A core counter at exactly one quarter of the peak. An inclusive comparison would flag that core as low.
- Sample sets above 127 that alias back into the sample group, together with the follower group values 5 and 127. A design that decodes the full set index would miss the aliased sets, and a design that decodes too few bits would pick up the followers.
- Prefetch fills and idle cycles. These must leave the policy counters untouched.
- Halving. One policy counter is driven to the ceiling, and the others are then pushed just past half of it. A design that merely saturates, or that halves only the counter that hit the ceiling, ends up selecting a different policy. The same halving event also leaves a core flag that only the halved core peak explains.

// File: rtl/ips_pkg.sv
`timescale 1ns/1ps
package ips_pkg;
    localparam int unsigned POLICIES_DEF = 5;
    localparam int unsigned CORES_DEF    = 4;
    localparam int unsigned CNT_W_DEF    = 12;
    localparam int unsigned SET_W_DEF    = 11;
    localparam int unsigned GROUP_W_DEF  = 7;
endpackage

// File: rtl/ips_halving_bank.sv
`timescale 1ns/1ps
// Group of saturating counters sharing one aging rule: when any of them
// would reach all-ones, every counter is halved on the same edge.
module ips_halving_bank #(
    parameter int unsigned N = 5,
    parameter int unsigned W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          bump,
    output logic [N-1:0][W-1:0]   count
);
    localparam logic [W-1:0] CEIL = '1;

    logic [N-1:0][W-1:0] raised;
    logic [N-1:0][W-1:0] next_count;
    logic                crest;

    always_comb begin
        crest = 1'b0;
        for (int i = 0; i < N; i++) begin
            raised[i] = count[i] + W'(bump[i]);
            if (raised[i] == CEIL) crest = 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            next_count[i] = crest ? (raised[i] >> 1) : raised[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= next_count;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R5 for the policy group, R8 for the core group
            p_below_ceil_r5: assert property (@(posedge clk) disable iff (!rst_n)
                count[g] != CEIL);
            p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!bump[g] && !crest) |=> $stable(count[g]));
            p_halved_r8: assert property (@(posedge clk) disable iff (!rst_n)
                crest |=> (count[g] <= (CEIL >> 1)));
        end
    endgenerate
endmodule

// File: rtl/ips_argmin.sv
`timescale 1ns/1ps
// Index of the smallest value; ties resolve to the lowest index.
module ips_argmin #(
    parameter int unsigned N     = 5,
    parameter int unsigned W     = 12,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] vals,
    output logic [IDX_W-1:0]    idx
);
    logic [W-1:0] lowest;

    always_comb begin
        idx    = '0;
        lowest = vals[0];
        for (int i = 1; i < N; i++) begin
            if (vals[i] < lowest) begin
                lowest = vals[i];
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ips_rate_judge.sv
`timescale 1ns/1ps
// Flags each entry whose count is below one quarter of the group peak.
module ips_rate_judge #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 12
) (
    input  logic [N-1:0][W-1:0] cnt,
    output logic [N-1:0]        low
);
    logic [W-1:0] peak;

    always_comb begin
        peak = '0;
        for (int i = 0; i < N; i++) begin
            if (cnt[i] > peak) peak = cnt[i];
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            low[i] = ({cnt[i], 2'b00} < {2'b00, peak});
        end
    end
endmodule

// File: rtl/ips_selector.sv
`timescale 1ns/1ps
module ips_selector #(
    parameter int unsigned POLICIES = ips_pkg::POLICIES_DEF,
    parameter int unsigned CORES    = ips_pkg::CORES_DEF,
    parameter int unsigned CNT_W    = ips_pkg::CNT_W_DEF,
    parameter int unsigned SET_W    = ips_pkg::SET_W_DEF,
    parameter int unsigned GROUP_W  = ips_pkg::GROUP_W_DEF,
    localparam int unsigned POL_W   = $clog2(POLICIES),
    localparam int unsigned CORE_W  = $clog2(CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [SET_W-1:0]  ins_set,
    input  logic              ins_demand,
    input  logic [CORE_W-1:0] ins_core,
    output logic [POL_W-1:0]  pol_sel,
    output logic [CORES-1:0]  core_low
);
    localparam logic [SET_W-1:0] GROUP_MASK = SET_W'((1 << GROUP_W) - 1);

    logic [SET_W-1:0]                slot;
    logic                            in_sample;
    logic [POLICIES-1:0]             pol_bump;
    logic [CORES-1:0]                core_bump;
    logic [POLICIES-1:0][CNT_W-1:0]  pol_cnt;
    logic [CORES-1:0][CNT_W-1:0]     core_cnt;

    assign slot      = ins_set & GROUP_MASK;
    assign in_sample = (slot < SET_W'(POLICIES));

    generate
        for (genvar p = 0; p < POLICIES; p++) begin : g_pol_dec
            assign pol_bump[p] = ins_valid && ins_demand && (slot == SET_W'(p));
        end
        for (genvar c = 0; c < CORES; c++) begin : g_core_dec
            assign core_bump[c] = ins_valid && (ins_core == CORE_W'(c));
        end
    endgenerate

    ips_halving_bank #(.N(POLICIES), .W(CNT_W)) u_pol_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (pol_bump),
        .count (pol_cnt)
    );

    ips_halving_bank #(.N(CORES), .W(CNT_W)) u_core_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (core_bump),
        .count (core_cnt)
    );

    ips_argmin #(.N(POLICIES), .W(CNT_W), .IDX_W(POL_W)) u_argmin (
        .vals (pol_cnt),
        .idx  (pol_sel)
    );

    ips_rate_judge #(.N(CORES), .W(CNT_W)) u_judge (
        .cnt (core_cnt),
        .low (core_low)
    );

    // R2: at most one policy counter is bumped per event
    p_one_bump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pol_bump));
    // R3: prefetch or follower fills leave policy counters alone
    p_follower_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (!ins_demand || !in_sample)) |=> $stable(pol_cnt));
    // R4: selection stays within the policy range
    p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pol_sel < POL_W'(POLICIES));
    generate
        for (genvar k = 0; k < POLICIES; k++) begin : g_min_chk
            // R4: the chosen policy's counter is no larger than any other
            p_sel_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
                pol_cnt[pol_sel] <= pol_cnt[k]);
        end
    endgenerate
    // R7: the core holding the peak is never flagged low
    p_peak_not_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_low != '1);
endmodule

// File: tb/tb_ips_selector.sv
`timescale 1ns/1ps
module tb_ips_selector;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid;
    logic [10:0] ins_set;
    logic        ins_demand;
    logic [1:0]  ins_core;
    logic [2:0]  pol_sel;
    logic [3:0]  core_low;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ips_selector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (ins_valid),
        .ins_set    (ins_set),
        .ins_demand (ins_demand),
        .ins_core   (ins_core),
        .pol_sel    (pol_sel),
        .core_low   (core_low)
    );

    // {valid, set[10:0], demand, core[1:0], exp_pol[2:0], exp_low[3:0]}
    localparam logic [21:0] VEC [0:13] = '{
        {1'b1, 11'd0,   1'b1, 2'd0, 3'd1, 4'b1110}, // R2 group 0
        {1'b1, 11'd1,   1'b1, 2'd1, 3'd2, 4'b1100}, // R2 group 1
        {1'b1, 11'd130, 1'b1, 2'd2, 3'd3, 4'b1000}, // R2 aliased group 2
        {1'b1, 11'd643, 1'b1, 2'd3, 3'd4, 4'b0000}, // R2 aliased group 3
        {1'b1, 11'd4,   1'b0, 2'd0, 3'd4, 4'b0000}, // R3 prefetch, R6 core still counts
        {1'b1, 11'd5,   1'b1, 2'd0, 3'd4, 4'b0000}, // R3 follower 5, R6
        {1'b1, 11'd127, 1'b1, 2'd0, 3'd4, 4'b0000}, // R3 follower 127, R6
        {1'b1, 11'd4,   1'b1, 2'd0, 3'd0, 4'b1110}, // R4 five-way tie -> policy 1
        {1'b1, 11'd0,   1'b1, 2'd1, 3'd1, 4'b1100}, // R4 four-way tie
        {1'b0, 11'd1,   1'b1, 2'd2, 3'd1, 4'b1100}, // R3 valid low
        {1'b1, 11'd1,   1'b1, 2'd0, 3'd2, 4'b1100}, // R4
        {1'b1, 11'd2,   1'b1, 2'd0, 3'd3, 4'b1100}, // R4
        {1'b1, 11'd3,   1'b1, 2'd0, 3'd4, 4'b1100}, // R7 core1 exactly a quarter
        {1'b1, 11'd4,   1'b1, 2'd0, 3'd0, 4'b1110}  // R7 core1 now below a quarter
    };

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_pol(input logic [2:0] exp, input string tag);
        checks++;
        if (pol_sel !== exp) begin
            errors++;
            $display("FAIL %s: pol_sel=%0d expected %0d", tag, pol_sel, exp);
        end
    endtask

    task automatic check_low(input logic [3:0] exp, input string tag);
        checks++;
        if (core_low !== exp) begin
            errors++;
            $display("FAIL %s: core_low=%b expected %b", tag, core_low, exp);
        end
    endtask

    task automatic step(input logic v, input logic [10:0] s, input logic d, input logic [1:0] c);
        ins_valid  = v;
        ins_set    = s;
        ins_demand = d;
        ins_core   = c;
        @(posedge clk);
        #1;
        ins_valid  = 1'b0;
    endtask

    task automatic pump(input int n, input logic [10:0] s, input logic [1:0] c);
        repeat (n) step(1'b1, s, 1'b1, c);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        ins_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_pol(3'd0, "R1 in reset");
        check_low(4'b0000, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        ins_set    = '0;
        ins_demand = 1'b0;
        ins_core   = '0;
        #1;
        do_reset();
        check_pol(3'd0, "R1 after reset");
        check_low(4'b0000, "R1 after reset");

        for (int i = 0; i < 14; i++) begin
            step(VEC[i][21], VEC[i][20:10], VEC[i][9], VEC[i][8:7]);
            check_pol(VEC[i][6:4], $sformatf("R4 vector %0d", i));
            check_low(VEC[i][3:0], $sformatf("R7 vector %0d", i));
        end

        // Halving: R5 and R8
        do_reset();
        pump(4094, 11'd0, 2'd0);
        check_pol(3'd1, "R4 before ceiling");
        check_low(4'b1110, "R7 before ceiling");
        pump(1, 11'd0, 2'd0);
        check_pol(3'd1, "R5 at ceiling");
        pump(600, 11'd5, 2'd1);
        check_pol(3'd1, "R3 follower after halving");
        check_low(4'b1100, "R8 core peak halved");
        pump(2048, 11'd1, 2'd1);
        check_pol(3'd2, "R4 after policy 2 pump");
        pump(2048, 11'd2, 2'd2);
        pump(2048, 11'd3, 2'd3);
        pump(2048, 11'd4, 2'd2);
        check_pol(3'd0, "R5 whole group halved");

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end
endmodule